// File: doc/BRIEF.md
# Sequenced ADC Power-Up and Conversion Controller

This block drives a multi-channel successive-approximation converter from a small 32-bit register interface. A single write to the control register selects one of up to eight inputs, enables the converter supply, and arms the interrupt. The controller then counts a programmable settling interval and sends the converter a one-cycle start strobe together with the channel number. It reports the conversion as busy until the converter answers with a done strobe.

When the done strobe arrives, the controller keeps the low result bits and flags completion in the control register. It raises an interrupt line if the interrupt is enabled. Software clears the completion flag by rewriting the control register with that flag bit at zero. Writing zero turns the converter off and abandons any sequence in progress. The analog converter itself is outside this block, and only its strobe-and-data handshake is modelled here.

Top module: `adcc_ctrl`

## Requirements
- R1: After reset, `conv_pwr`, `conv_start` and `irq` are 0. Register reads return 0 for the result (byte offset 0x00), the status (0x04) and the control (0x08) registers, and 8 for the settle register (0x0C).
- R2: The settle register keeps only its low 6 bits. Control reads return the channel in bits [2:0], power in bit 3, interrupt enable in bit 5 and completion flag in bit 6, with every other bit at 0. Any address other than the four offsets reads 0. Read data appears one cycle after the read strobe.
- R3: A control write that changes bit 3 from 0 to 1 raises `conv_pwr`. With a settle value D, it produces a `conv_start` pulse exactly one cycle long, D+1 clock edges after the write edge. During that pulse, `conv_chan` carries the written bits [2:0].
- R4: Status bit 0 (busy) rises on the same edge as `conv_start` and remains 1 until the done strobe is taken.
- R5: A `conv_done` during a conversion loads the low 10 bits of `conv_data` into the result register, with upper bits discarded and read as 0. It clears busy and sets control bit 6.
- R6: `irq` is 1 exactly when control bit 6 and control bit 5 are both 1.
- R7: A control write with bit 6 at 0 clears the completion flag. A write with bit 6 at 1 leaves it unchanged.
- R8: A control write with bit 3 at 0 drops `conv_pwr`. If that write comes during the settle interval, no start pulse follows. If it comes during a conversion, busy clears and a later `conv_done` loads nothing and sets no flag.
- R9: A control write with bit 3 at 1 while power is already on does not start a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Completion interrupt |
| conv_pwr | output | 1 | Converter supply enable |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 3 | Channel for the conversion |
| conv_done | input | 1 | Converter result-ready strobe |
| conv_data | input | 16 | Raw converter result |

## Verification
The assertions check on every cycle that:
- the start strobe never lasts more than one cycle and only occurs while power is on;
- busy can only rise together with a start strobe;
- a power-down write always leaves busy low and no strobe behind;
- an accepted result always sets the completion flag, and a clearing write clears it.

Only the bench scenarios can show the exact settle count for each value of D, the channel presented and the masked result value. They also show that a late done strobe after an abort changes nothing, and that rewriting power while already on starts nothing.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  localparam int OFS_DATA = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_CTRL = 'h08;
  localparam int OFS_DLY  = 'h0C;

  localparam int BUSY_BIT = 0;
  localparam int PWR_BIT  = 3;
  localparam int IE_BIT   = 5;
  localparam int ST_BIT   = 6;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_CONV = 2'd2
  } seq_st_e;
endpackage

// File: rtl/adcc_regs.sv
module adcc_regs
  import adcc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int RES_W   = 10,
  parameter int RAW_W   = 16,
  parameter int CH_W    = 3,
  parameter int DLY_W   = 6,
  parameter int DLY_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              res_ld,
  input  logic [RAW_W-1:0]  conv_data,
  output logic              pwr,
  output logic              ie,
  output logic              irq_st,
  output logic [CH_W-1:0]   ch,
  output logic [DLY_W-1:0]  dly,
  output logic              on_evt,
  output logic              off_evt
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DLY  = ADDR_W'(OFS_DLY);

  logic [RES_W-1:0] res_q;
  logic             wr_ctrl;
  logic [DATA_W-1:0] ctrl_view;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign on_evt  = wr_ctrl && bus_wdata[PWR_BIT] && !pwr;
  assign off_evt = wr_ctrl && !bus_wdata[PWR_BIT];

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CH_W-1:0] = ch;
    ctrl_view[PWR_BIT]  = pwr;
    ctrl_view[IE_BIT]   = ie;
    ctrl_view[ST_BIT]   = irq_st;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr    <= 1'b0;
      ie     <= 1'b0;
      ch     <= '0;
      irq_st <= 1'b0;
      dly    <= DLY_W'(DLY_RST);
      res_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        pwr <= bus_wdata[PWR_BIT];
        ie  <= bus_wdata[IE_BIT];
        ch  <= bus_wdata[CH_W-1:0];
      end
      if (bus_wr && bus_addr == A_DLY)
        dly <= bus_wdata[DLY_W-1:0];
      if (res_ld) begin
        res_q  <= conv_data[RES_W-1:0];
        irq_st <= 1'b1;
      end else if (wr_ctrl && !bus_wdata[ST_BIT]) begin
        irq_st <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata <= DATA_W'(res_q);
        A_STAT:  bus_rdata <= DATA_W'(busy);
        A_CTRL:  bus_rdata <= ctrl_view;
        A_DLY:   bus_rdata <= DATA_W'(dly);
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R5
  ld_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_ld |=> irq_st);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[ST_BIT] && !res_ld) |=> !irq_st);
endmodule

// File: rtl/adcc_seq.sv
module adcc_seq
  import adcc_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on_evt,
  input  logic             off_evt,
  input  logic             pwr,
  input  logic [DLY_W-1:0] dly,
  input  logic [CH_W-1:0]  ch,
  input  logic             conv_done,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic             busy,
  output logic             res_ld
);
  seq_st_e          st;
  logic [DLY_W-1:0] cnt;

  assign res_ld = (st == S_CONV) && conv_done && !off_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      busy       <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (off_evt) begin
        st   <= S_IDLE;
        busy <= 1'b0;
      end else if (on_evt) begin
        st  <= S_WAIT;
        cnt <= dly;
      end else begin
        case (st)
          S_WAIT: begin
            if (cnt == '0) begin
              conv_start <= 1'b1;
              conv_chan  <= ch;
              busy       <= 1'b1;
              st         <= S_CONV;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_CONV: begin
            if (conv_done) begin
              busy <= 1'b0;
              st   <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R3
  start_powered_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> pwr);
  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> conv_start);
  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    off_evt |=> (!busy && !conv_start));
endmodule

// File: rtl/adcc_ctrl.sv
module adcc_ctrl #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int RES_W   = 10,
  parameter int RAW_W   = 16,
  parameter int CH_W    = 3,
  parameter int DLY_W   = 6,
  parameter int DLY_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              conv_pwr,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RAW_W-1:0]  conv_data
);
  logic             pwr, ie, irq_st, on_evt, off_evt, busy, res_ld;
  logic [CH_W-1:0]  ch;
  logic [DLY_W-1:0] dly;

  adcc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RES_W(RES_W), .RAW_W(RAW_W),
    .CH_W(CH_W), .DLY_W(DLY_W), .DLY_RST(DLY_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .res_ld(res_ld), .conv_data(conv_data),
    .pwr(pwr), .ie(ie), .irq_st(irq_st), .ch(ch), .dly(dly),
    .on_evt(on_evt), .off_evt(off_evt)
  );

  adcc_seq #(.CH_W(CH_W), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst),
    .on_evt(on_evt), .off_evt(off_evt), .pwr(pwr), .dly(dly), .ch(ch),
    .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
    .busy(busy), .res_ld(res_ld)
  );

  assign conv_pwr = pwr;
  assign irq      = irq_st && ie;
endmodule

// File: tb/adcc_ctrl_test.sv
module adcc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, conv_pwr, conv_start, conv_done = 1'b0;
  logic [2:0]  conv_chan;
  logic [15:0] conv_data = '0;
  int total = 0, bad = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  adcc_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .conv_pwr(conv_pwr), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data)
  );

  // vector: {ch[2:0], dly[5:0], raw[15:0], ie}
  localparam logic [25:0] VECS [0:4] = '{
    {3'd7, 6'd0,  16'hFFFF, 1'b1},
    {3'd0, 6'd8,  16'h1234, 1'b0},
    {3'd5, 6'd63, 16'h03FF, 1'b1},
    {3'd2, 6'd1,  16'h0C00, 1'b1},
    {3'd3, 6'd3,  16'h05A5, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic done_pulse(input logic [15:0] raw);
    @(negedge clk); conv_done = 1'b1; conv_data = raw;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic count_starts(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (conv_start) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pwr", 32'(conv_pwr), 0);
    check("R1 start", 32'(conv_start), 0);
    check("R1 irq", 32'(irq), 0);
    rd(5'h00, d); check("R1 data", d, 0);
    rd(5'h04, d); check("R1 status", d, 0);
    rd(5'h08, d); check("R1 ctrl", d, 0);
    rd(5'h0C, d); check("R1 settle", d, 8);

    // R2 field layout
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, d); check("R2 settle mask", d, 32'h3F);
    wr(5'h08, 32'hFFFF_FF97); rd(5'h08, d); check("R2 ctrl bits", d, 32'h07);
    rd(5'h14, d); check("R2 unmapped", d, 0);

    // R3 R4 R5 R6 table walk
    for (int v = 0; v < 5; v++) begin
      logic [2:0]  ch;
      logic [5:0]  dl;
      logic [15:0] raw;
      logic        ie;
      {ch, dl, raw, ie} = VECS[v];
      wr(5'h08, 32'h0);
      wr(5'h0C, 32'(dl));
      wr(5'h08, 32'h8 | (32'(ie) << 5) | 32'(ch));
      check("R3 pwr", 32'(conv_pwr), 1);
      n = 0;
      while (!conv_start && n < 200) begin @(negedge clk); n++; end
      check("R3 settle count", n, 32'(dl) + 1);
      check("R3 chan", 32'(conv_chan), 32'(ch));
      @(negedge clk);
      check("R3 single pulse", 32'(conv_start), 0);
      rd(5'h04, d); check("R4 busy", d, 1);
      done_pulse(raw);
      rd(5'h00, d); check("R5 data", d, 32'(raw & 16'h03FF));
      rd(5'h04, d); check("R5 busy clear", d, 0);
      rd(5'h08, d); check("R5 flag", 32'(d[6]), 1);
      check("R6 irq", 32'(irq), 32'(ie));
    end

    // R9 rewrite with power already on (last vector left it on, ie=0)
    wr(5'h08, 32'h0000_0068);
    check("R6 irq enabled", 32'(irq), 1);
    count_starts(80, n); check("R9 no restart", n, 0);
    // R7 bit6 set keeps flag, bit6 clear drops it
    rd(5'h08, d); check("R7 flag kept", 32'(d[6]), 1);
    wr(5'h08, 32'h0000_0028);
    rd(5'h08, d); check("R7 flag cleared", 32'(d[6]), 0);
    check("R7 irq low", 32'(irq), 0);

    // R8 abort during settle
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'd20);
    wr(5'h08, 32'h2C);
    repeat (5) @(negedge clk);
    wr(5'h08, 32'h0);
    check("R8 pwr off", 32'(conv_pwr), 0);
    count_starts(40, n); check("R8 no start after abort", n, 0);

    // R8 abort during conversion, late done ignored
    wr(5'h0C, 32'd2);
    wr(5'h08, 32'h29);
    n = 0;
    while (!conv_start && n < 50) begin @(negedge clk); n++; end
    check("R8 started", 32'(conv_start), 1);
    wr(5'h08, 32'h20);
    rd(5'h04, d); check("R8 busy cleared", d, 0);
    done_pulse(16'h0111);
    rd(5'h00, d); check("R8 data unchanged", d, 32'h1A5);
    rd(5'h08, d); check("R8 no flag", 32'(d[6]), 0);
    check("R8 irq low", 32'(irq), 0);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule